// File: doc/BRIEF.md
# Hash Context Register Bank

This block is the software-visible state store that sits beside a SHA-2/HMAC compression engine. It keeps the sixteen running digest words and the 64-bit count of message bits received, and it presents a status word that mirrors the engine's idle flag and the message FIFO's fill state. Software saves a hash context by reading the digest and length words and restores it by writing them back. Restore writes are honoured only while the status word reports the engine idle. A write issued while the engine is busy is discarded and recorded in a sticky flag.

The hashing datapath reaches the same digest and length registers through a dedicated hardware port. That port wins over a software write in the same cycle, and it is not gated by the idle state. A control word holds the SHA enable and a digest mode. Dropping the enable from 1 to 0 wipes the digest one cycle later. The enable also gates the compression start request that the engine raises.

Accesses use a simple word-addressed bus. Reads return data one cycle after the request.

Top module: `hash_ctx_regs`

## Requirements
- R1: After reset the digest words, both length words, the control word and the sticky flag are all zero.
- R2: When the SHA enable bit goes from 1 to 0, every digest word is still unchanged on the next clock edge and is zero after the edge that follows.
- R3: A bus write to a digest word (byte addresses 0x40 + 4·i, i = 0..15), to length-low (0x10) or to length-high (0x14) changes that register only when the registered idle status bit is 1. Otherwise the register keeps its value.
- R4: Bits [2:0] of the length-low word are always zero, whether it is written by software or by hardware. The length output is 128 bits wide: {64'b0, high word, low word}.
- R5: The status word at 0x04 is read-only and is laid out as follows:
  - bit 0: idle
  - bit 1: FIFO empty
  - bit 2: FIFO full
  - bits 9:4: FIFO entry count
  - all other bits: zero

  The status word samples its inputs one cycle late. It reads 0x3 on the first cycle after reset is released, whatever the inputs are.
- R6: Control bits [2:1] select the digest mode: 0 = 256, 1 = 384, 2 = 512 and 3 behaves as 512. In the 384 mode, digest words 12 to 15 read as zero. The digest output carries word 0 in its most significant 32 bits.
- R7: The compression start output equals the start request ANDed with the SHA enable, registered by one cycle. It is never 1 while the enable was 0.
- R8: The read valid output and the read data appear one cycle after a read request. An address that maps to no register reads zero and ignores writes. This includes any address whose bits [1:0] are not zero, and 0x0C.
- R9: A rejected write of the kind described in R3 sets the sticky flag (bit 0 at 0x08). Writing 1 to that bit clears the flag, writing 0 leaves it set, and a new rejection in the same cycle keeps it set.
- R10: A hardware digest or length update is applied whatever the idle state. It takes priority over a software write to the same register in the same cycle.
- R11: Control word bit 0 is the SHA enable. Bits [2:1] are the mode. All other control bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Bus write strobe |
| bus_rd_en | input | 1 | Bus read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd_en |
| hw_dig_we | input | 16 | Per-word hardware digest update, bit i = word i |
| hw_dig_data | input | 512 | Hardware digest data, word 0 in the top 32 bits |
| hw_len_we | input | 1 | Hardware length update |
| hw_len_data | input | 64 | Hardware length value {high, low} |
| eng_idle | input | 1 | Engine idle indication |
| fifo_empty | input | 1 | Message FIFO empty |
| fifo_full | input | 1 | Message FIFO full |
| fifo_count | input | 6 | Message FIFO entry count |
| comp_req | input | 1 | Compression start request from the engine |
| comp_start | output | 1 | Gated, registered compression start |
| digest_o | output | 512 | Digest words, word 0 most significant |
| msg_len_o | output | 128 | Message bit length, upper 64 bits zero |

## Verification
A corrupted digest or length register shows on `digest_o` and `msg_len_o` at the very next clock edge, because both outputs come straight from the state flops. The bench compares them against its own model every cycle. A wrong sticky flag, a wrong status sample or a wrong mode surfaces only through a bus read, and only one cycle after that read is requested. These are covered by directed reads and by the random phase, which reads every register repeatedly. A wrong enable history shows two edges after the enable falls, when the digest fails to clear. It also shows one edge after a start request, on `comp_start`.

// File: rtl/hash_ctx_pkg.sv
package hash_ctx_pkg;

  // word addresses (byte address >> 2)
  localparam int unsigned CTRL_WA   = 0;
  localparam int unsigned STAT_WA   = 1;
  localparam int unsigned FLAG_WA   = 2;
  localparam int unsigned LEN_LO_WA = 4;
  localparam int unsigned LEN_HI_WA = 5;
  localparam int unsigned DIG_WA    = 16;

  typedef enum logic [1:0] {
    MODE_256 = 2'd0,
    MODE_384 = 2'd1,
    MODE_512 = 2'd2,
    MODE_RSV = 2'd3
  } hash_mode_e;

endpackage

// File: rtl/hash_ctx_digest_bank.sv
module hash_ctx_digest_bank #(
  parameter int WORDS  = 16,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic [WORDS-1:0]        sw_we,
  input  logic [DATA_W-1:0]       sw_data,
  input  logic [WORDS-1:0]        hw_we,
  input  logic [WORDS*DATA_W-1:0] hw_data,
  output logic [DATA_W-1:0]       word_q [WORDS]
);

  // one register per word: clear beats hardware, hardware beats software
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst || clear) begin
        word_q[g] <= '0;
      end else if (hw_we[g]) begin
        word_q[g] <= hw_data[(WORDS-1-g)*DATA_W +: DATA_W];
      end else if (sw_we[g]) begin
        word_q[g] <= sw_data;
      end
    end
  end

endmodule

// File: rtl/hash_ctx_len_reg.sv
module hash_ctx_len_reg #(
  parameter int DATA_W  = 32,
  parameter int LSB_IGN = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sw_we_lo,
  input  logic                  sw_we_hi,
  input  logic [DATA_W-1:0]     sw_data,
  input  logic                  hw_we,
  input  logic [2*DATA_W-1:0]   hw_data,
  output logic [2*DATA_W-1:0]   len_q
);

  localparam logic [DATA_W-1:0] LO_MASK = ~DATA_W'((1 << LSB_IGN) - 1);

  logic [DATA_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (hw_we) begin
      lo_q <= hw_data[DATA_W-1:0] & LO_MASK;
      hi_q <= hw_data[2*DATA_W-1:DATA_W];
    end else begin
      if (sw_we_lo) lo_q <= sw_data & LO_MASK;
      if (sw_we_hi) hi_q <= sw_data;
    end
  end

  assign len_q = {hi_q, lo_q};

endmodule

// File: rtl/hash_ctx_status.sv
module hash_ctx_status #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eng_idle,
  input  logic              fifo_empty,
  input  logic              fifo_full,
  input  logic [CNT_W-1:0]  fifo_count,
  output logic              idle_q,
  output logic [DATA_W-1:0] status_word
);

  localparam int PAD_W = DATA_W - 4 - CNT_W;

  logic             empty_q, full_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_q  <= 1'b1;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      idle_q  <= eng_idle;
      empty_q <= fifo_empty;
      full_q  <= fifo_full;
      cnt_q   <= fifo_count;
    end
  end

  assign status_word = {{PAD_W{1'b0}}, cnt_q, 1'b0, full_q, empty_q, idle_q};

endmodule

// File: rtl/hash_ctx_regs.sv
module hash_ctx_regs
  import hash_ctx_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int DIG_WORDS = 16,
  parameter int CNT_W     = 6,
  parameter int LEN_LSB   = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_wr_en,
  input  logic                       bus_rd_en,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic                       bus_rvalid,
  input  logic [DIG_WORDS-1:0]       hw_dig_we,
  input  logic [DIG_WORDS*DATA_W-1:0] hw_dig_data,
  input  logic                       hw_len_we,
  input  logic [2*DATA_W-1:0]        hw_len_data,
  input  logic                       eng_idle,
  input  logic                       fifo_empty,
  input  logic                       fifo_full,
  input  logic [CNT_W-1:0]           fifo_count,
  input  logic                       comp_req,
  output logic                       comp_start,
  output logic [DIG_WORDS*DATA_W-1:0] digest_o,
  output logic [4*DATA_W-1:0]        msg_len_o
);

  localparam int WA_W       = ADDR_W - 2;
  localparam int IDX_W      = $clog2(DIG_WORDS);
  localparam int TRUNC_FROM = DIG_WORDS - DIG_WORDS / 4;

  // ---------------- address decode ----------------
  logic [WA_W-1:0]  wa;
  logic             aligned;
  logic             hit_ctrl, hit_stat, hit_flag, hit_lo, hit_hi, hit_dig;
  logic [IDX_W-1:0] dig_idx;

  assign wa      = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  always_comb begin
    hit_ctrl = aligned && (wa == WA_W'(CTRL_WA));
    hit_stat = aligned && (wa == WA_W'(STAT_WA));
    hit_flag = aligned && (wa == WA_W'(FLAG_WA));
    hit_lo   = aligned && (wa == WA_W'(LEN_LO_WA));
    hit_hi   = aligned && (wa == WA_W'(LEN_HI_WA));
    hit_dig  = aligned && (wa >= WA_W'(DIG_WA)) && (wa < WA_W'(DIG_WA + DIG_WORDS));
    dig_idx  = IDX_W'(wa - WA_W'(DIG_WA));
  end

  // ---------------- status ----------------
  logic              idle_q;
  logic [DATA_W-1:0] status_word;

  hash_ctx_status #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_status (
    .clk        (clk),
    .rst        (rst),
    .eng_idle   (eng_idle),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .fifo_count (fifo_count),
    .idle_q     (idle_q),
    .status_word(status_word)
  );

  // ---------------- context write gating ----------------
  logic                 ctx_wr, ctx_ok, ctx_rej;
  logic [DIG_WORDS-1:0] sw_dig_we;

  assign ctx_wr  = bus_wr_en && (hit_dig || hit_lo || hit_hi);
  assign ctx_ok  = ctx_wr && idle_q;
  assign ctx_rej = ctx_wr && !idle_q;

  always_comb begin
    for (int i = 0; i < DIG_WORDS; i++) begin
      sw_dig_we[i] = ctx_ok && hit_dig && (dig_idx == IDX_W'(i));
    end
  end

  // ---------------- control ----------------
  logic       sha_en_q, sha_prev_q, dig_clear;
  hash_mode_e mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sha_en_q   <= 1'b0;
      sha_prev_q <= 1'b0;
      mode_q     <= MODE_256;
    end else begin
      sha_prev_q <= sha_en_q;
      if (bus_wr_en && hit_ctrl) begin
        sha_en_q <= bus_wdata[0];
        mode_q   <= hash_mode_e'(bus_wdata[2:1]);
      end
    end
  end

  assign dig_clear = sha_prev_q && !sha_en_q;

  // ---------------- sticky rejection flag ----------------
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else if (ctx_rej) begin
      flag_q <= 1'b1;
    end else if (bus_wr_en && hit_flag && bus_wdata[0]) begin
      flag_q <= 1'b0;
    end
  end

  // ---------------- compression start gate ----------------
  always_ff @(posedge clk) begin
    if (rst) comp_start <= 1'b0;
    else     comp_start <= comp_req && sha_en_q;
  end

  // ---------------- storage ----------------
  logic [DATA_W-1:0]   word_q [DIG_WORDS];
  logic [2*DATA_W-1:0] len_q;

  hash_ctx_digest_bank #(.WORDS(DIG_WORDS), .DATA_W(DATA_W)) u_digest (
    .clk    (clk),
    .rst    (rst),
    .clear  (dig_clear),
    .sw_we  (sw_dig_we),
    .sw_data(bus_wdata),
    .hw_we  (hw_dig_we),
    .hw_data(hw_dig_data),
    .word_q (word_q)
  );

  hash_ctx_len_reg #(.DATA_W(DATA_W), .LSB_IGN(LEN_LSB)) u_len (
    .clk     (clk),
    .rst     (rst),
    .sw_we_lo(ctx_ok && hit_lo),
    .sw_we_hi(ctx_ok && hit_hi),
    .sw_data (bus_wdata),
    .hw_we   (hw_len_we),
    .hw_data (hw_len_data),
    .len_q   (len_q)
  );

  for (genvar g = 0; g < DIG_WORDS; g++) begin : g_out
    assign digest_o[(DIG_WORDS-1-g)*DATA_W +: DATA_W] = word_q[g];
  end

  assign msg_len_o = {{(2*DATA_W){1'b0}}, len_q};

  // ---------------- read path ----------------
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl)      rd_mux = DATA_W'({mode_q, sha_en_q});
    else if (hit_stat) rd_mux = status_word;
    else if (hit_flag) rd_mux = DATA_W'(flag_q);
    else if (hit_lo)   rd_mux = len_q[DATA_W-1:0];
    else if (hit_hi)   rd_mux = len_q[2*DATA_W-1:DATA_W];
    else if (hit_dig) begin
      if (mode_q == MODE_384 && int'(dig_idx) >= TRUNC_FROM) rd_mux = '0;
      else                                                   rd_mux = word_q[dig_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd_en;
      if (bus_rd_en) bus_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/hash_ctx_regs_chk.sv
module hash_ctx_regs_chk #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int DIG_WORDS = 16
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        bus_wr_en,
  input logic                        bus_rd_en,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic                        bus_rvalid,
  input logic                        hw_len_we,
  input logic [2*DATA_W-1:0]         hw_len_data,
  input logic                        comp_start,
  input logic [DIG_WORDS*DATA_W-1:0] digest_o,
  input logic [4*DATA_W-1:0]         msg_len_o,
  input logic                        sha_en_q,
  input logic                        idle_q,
  input logic                        flag_q,
  input logic                        ctx_wr
);

  logic len_addr;
  assign len_addr = (bus_addr == ADDR_W'(8'h10)) || (bus_addr == ADDR_W'(8'h14));

  // R2
  dig_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sha_en_q) |=> (digest_o == '0));

  // R3
  len_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && len_addr && !idle_q && !hw_len_we) |=> $stable(msg_len_o));

  // R4
  len_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_len_o[2:0] == 3'b000) && (msg_len_o[4*DATA_W-1:2*DATA_W] == '0));

  // R7
  start_gate_chk: assert property (@(posedge clk) disable iff (rst)
    comp_start |-> $past(sha_en_q));

  // R8
  rvalid_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd_en |=> bus_rvalid);

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (ctx_wr && !idle_q) |=> flag_q);

  // R10
  hw_len_prio_chk: assert property (@(posedge clk) disable iff (rst)
    hw_len_we |=> (msg_len_o[2*DATA_W-1:3] == $past(hw_len_data[2*DATA_W-1:3])));

endmodule

bind hash_ctx_regs hash_ctx_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIG_WORDS(DIG_WORDS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr_en  (bus_wr_en),
  .bus_rd_en  (bus_rd_en),
  .bus_addr   (bus_addr),
  .bus_rvalid (bus_rvalid),
  .hw_len_we  (hw_len_we),
  .hw_len_data(hw_len_data),
  .comp_start (comp_start),
  .digest_o   (digest_o),
  .msg_len_o  (msg_len_o),
  .sha_en_q   (sha_en_q),
  .idle_q     (idle_q),
  .flag_q     (flag_q),
  .ctx_wr     (ctx_wr)
);

// File: tb/test_hash_ctx_regs.sv
module test_hash_ctx_regs;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         bus_rvalid;
  logic [15:0]  hw_dig_we = '0;
  logic [511:0] hw_dig_data = '0;
  logic         hw_len_we = 1'b0;
  logic [63:0]  hw_len_data = '0;
  logic         eng_idle = 1'b0, fifo_empty = 1'b0, fifo_full = 1'b1;
  logic [5:0]   fifo_count = 6'd5;
  logic         comp_req = 1'b0;
  logic         comp_start;
  logic [511:0] digest_o;
  logic [127:0] msg_len_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  hash_ctx_regs i_hash_ctx_regs (
    .clk(clk), .rst(rst),
    .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .hw_dig_we(hw_dig_we), .hw_dig_data(hw_dig_data),
    .hw_len_we(hw_len_we), .hw_len_data(hw_len_data),
    .eng_idle(eng_idle), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .fifo_count(fifo_count), .comp_req(comp_req), .comp_start(comp_start),
    .digest_o(digest_o), .msg_len_o(msg_len_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_dig [16];
  logic [63:0] m_len;
  bit          m_en, m_prev, m_idle, m_empty, m_full, m_flag, m_rv, m_start;
  logic [1:0]  m_mode;
  logic [5:0]  m_cnt;
  logic [31:0] m_rd;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    int w;
    if (a[1:0] != 2'b00) return 32'h0;
    w = int'(a[7:2]);
    if (w == 0) return {29'h0, m_mode, m_en};
    if (w == 1) return {22'h0, m_cnt, 1'b0, m_full, m_empty, m_idle};
    if (w == 2) return {31'h0, m_flag};
    if (w == 4) return m_len[31:0];
    if (w == 5) return m_len[63:32];
    if (w >= 16 && w < 32) begin
      if (m_mode == 2'd1 && (w - 16) >= 12) return 32'h0;
      return m_dig[w-16];
    end
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_dig[i]) m_dig[i] = '0;
      m_len = '0; m_en = 0; m_prev = 0; m_mode = 0; m_flag = 0;
      m_idle = 1; m_empty = 1; m_full = 0; m_cnt = 0;
      m_rv = 0; m_rd = '0; m_start = 0;
    end else begin
      int  w;
      bit  ok, ctx;
      w   = int'(bus_addr[7:2]);
      ok  = m_idle;
      ctx = bus_wr_en && bus_addr[1:0] == 2'b00 && (w == 4 || w == 5 || (w >= 16 && w < 32));
      if (bus_rd_en) m_rd = m_read(bus_addr);
      m_rv = bus_rd_en;
      for (int i = 0; i < 16; i++) begin
        if (m_prev && !m_en)                   m_dig[i] = '0;
        else if (hw_dig_we[i])                 m_dig[i] = hw_dig_data[(15-i)*32 +: 32];
        else if (ctx && ok && w == 16 + i)     m_dig[i] = bus_wdata;
      end
      if (hw_len_we) m_len = {hw_len_data[63:3], 3'b000};
      else if (ctx && ok && w == 4) m_len[31:0] = {bus_wdata[31:3], 3'b000};
      else if (ctx && ok && w == 5) m_len[63:32] = bus_wdata;
      m_start = comp_req && m_en;
      if (ctx && !ok) m_flag = 1;
      else if (bus_wr_en && bus_addr == 8'h08 && bus_wdata[0]) m_flag = 0;
      m_idle = eng_idle; m_empty = fifo_empty; m_full = fifo_full; m_cnt = fifo_count;
      m_prev = m_en;
      if (bus_wr_en && bus_addr == 8'h00) begin
        m_en = bus_wdata[0];
        m_mode = bus_wdata[2:1];
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      logic [511:0] ed;
      for (int i = 0; i < 16; i++) ed[(15-i)*32 +: 32] = m_dig[i];
      chk(digest_o == ed, "R2/R3/R10 digest_o", digest_o, ed);
      chk(msg_len_o == {64'h0, m_len}, "R4/R10 msg_len_o", 512'(msg_len_o), 512'({64'h0, m_len}));
      chk(comp_start == m_start, "R7 comp_start", 512'(comp_start), 512'(m_start));
      chk(bus_rvalid == m_rv, "R8 rvalid", 512'(bus_rvalid), 512'(m_rv));
      if (m_rv) chk(bus_rdata == m_rd, "R8 rdata model", 512'(bus_rdata), 512'(m_rd));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr_en = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 0;
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_rd_en = 1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 0;
    chk(bus_rvalid == 1'b1, "R8 rvalid", 512'(bus_rvalid), 512'(1));
    chk(bus_rdata == exp, tag, 512'(bus_rdata), 512'(exp));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<50000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R5: reset values held for one cycle, FIFO inputs sampled after
    rd_exp(8'h04, 32'h3, "R5 status first cycle");
    rd_exp(8'h04, 32'h54, "R5 status sampled");
    // R1
    rd_exp(8'h40, 32'h0, "R1 digest reset");
    rd_exp(8'h00, 32'h0, "R1 ctrl reset");
    rd_exp(8'h08, 32'h0, "R1 flag reset");
    rd_exp(8'h10, 32'h0, "R1 len reset");
    eng_idle = 1; fifo_empty = 1; fifo_full = 0; fifo_count = 0;
    @(negedge clk);
    rd_exp(8'h04, 32'h3, "R1 status idle");
    // R11
    wr(8'h00, 32'hFFFF_FFFF);
    rd_exp(8'h00, 32'h7, "R11 ctrl reserved");
    wr(8'h00, 32'h1);
    rd_exp(8'h00, 32'h1, "R11 ctrl");
    // R3 idle writes
    wr(8'h40, 32'h1111_1111);
    wr(8'h7C, 32'hFFFF_0000);
    rd_exp(8'h40, 32'h1111_1111, "R3 word0 idle write");
    rd_exp(8'h7C, 32'hFFFF_0000, "R3 word15 idle write");
    // R4
    wr(8'h10, 32'h1234_5677);
    wr(8'h14, 32'h0000_ABCD);
    rd_exp(8'h10, 32'h1234_5670, "R4 low bits dropped");
    rd_exp(8'h14, 32'h0000_ABCD, "R4 high word");
    chk(msg_len_o == {64'h0, 32'hABCD, 32'h1234_5670}, "R4 wide length",
        512'(msg_len_o), 512'({64'h0, 32'hABCD, 32'h1234_5670}));
    // R6
    chk(digest_o[511:480] == 32'h1111_1111, "R6 word0 msb", 512'(digest_o[511:480]), 512'(32'h1111_1111));
    chk(digest_o[31:0] == 32'hFFFF_0000, "R6 word15 lsb", 512'(digest_o[31:0]), 512'(32'hFFFF_0000));
    wr(8'h00, 32'h3);
    rd_exp(8'h7C, 32'h0, "R6 384 truncation");
    rd_exp(8'h40, 32'h1111_1111, "R6 384 word0");
    wr(8'h00, 32'h5);
    rd_exp(8'h7C, 32'hFFFF_0000, "R6 512 word15");
    // R3 / R9 busy writes
    eng_idle = 0;
    @(negedge clk);
    wr(8'h40, 32'hDEAD_BEEF);
    wr(8'h14, 32'h1);
    rd_exp(8'h40, 32'h1111_1111, "R3 busy digest write dropped");
    rd_exp(8'h14, 32'h0000_ABCD, "R3 busy length write dropped");
    rd_exp(8'h08, 32'h1, "R9 flag set");
    wr(8'h08, 32'h0);
    rd_exp(8'h08, 32'h1, "R9 flag sticky");
    wr(8'h08, 32'h1);
    rd_exp(8'h08, 32'h0, "R9 flag cleared");
    // R10
    hw_len_we = 1; hw_len_data = 64'hFFFF_FFFF_FFFF_FFFF;
    @(negedge clk);
    hw_len_we = 0;
    rd_exp(8'h10, 32'hFFFF_FFF8, "R10 hw length while busy");
    eng_idle = 1;
    @(negedge clk);
    bus_wr_en = 1; bus_addr = 8'h4C; bus_wdata = 32'hAAAA;
    hw_dig_we = 16'h0008; hw_dig_data = '0; hw_dig_data[12*32 +: 32] = 32'h5555;
    @(negedge clk);
    bus_wr_en = 0; hw_dig_we = '0;
    rd_exp(8'h4C, 32'h5555, "R10 hw beats sw");
    // R7 and R2
    comp_req = 1;
    @(negedge clk);
    chk(comp_start == 1'b1, "R7 start passes", 512'(comp_start), 512'(1));
    wr(8'h00, 32'h4);
    chk(digest_o != '0, "R2 not cleared yet", digest_o, 512'(1));
    @(negedge clk);
    chk(digest_o == '0, "R2 cleared", digest_o, 512'(0));
    chk(comp_start == 1'b0, "R7 start gated", 512'(comp_start), 512'(0));
    comp_req = 0;
    // R8 / R5
    rd_exp(8'h0C, 32'h0, "R8 unmapped");
    wr(8'h41, 32'h1234);
    rd_exp(8'h41, 32'h0, "R8 misaligned read");
    rd_exp(8'h40, 32'h0, "R8 misaligned write ignored");
    wr(8'h04, 32'hFFFF_FFFF);
    rd_exp(8'h04, 32'h3, "R5 status read-only");
    // random phase against the model
    for (int n = 0; n < 2000; n++) begin
      int sel;
      sel = int'($urandom % 8);
      case (sel)
        0: bus_addr = 8'h00;
        1: bus_addr = 8'h04;
        2: bus_addr = 8'h08;
        3: bus_addr = 8'h10;
        4: bus_addr = 8'h14;
        default: bus_addr = 8'h40 + 8'(($urandom % 16) * 4);
      endcase
      if ($urandom % 16 == 0) bus_addr = bus_addr + 8'h2;
      bus_wdata = $urandom;
      bus_wr_en = ($urandom % 3 == 0);
      bus_rd_en = ($urandom % 2 == 0);
      hw_dig_we = ($urandom % 6 == 0) ? 16'($urandom) : 16'h0;
      for (int k = 0; k < 16; k++) hw_dig_data[k*32 +: 32] = $urandom;
      hw_len_we = ($urandom % 8 == 0);
      hw_len_data = {$urandom, $urandom};
      if ($urandom % 4 == 0) eng_idle = ~eng_idle;
      fifo_empty = 1'($urandom); fifo_full = 1'($urandom); fifo_count = 6'($urandom);
      comp_req = 1'($urandom);
      @(negedge clk);
    end
    bus_wr_en = 0; bus_rd_en = 0; hw_dig_we = '0; hw_len_we = 0;
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule